// File: doc/BRIEF.md
# 36-Bit Single-Word Shifter and Rotator

This unit performs one of three operations on a 36-bit word: a logical shift, a rotate, or an arithmetic shift. A caller presents the data word, an 18-bit two's-complement count and a two-bit operation code, and then raises `start` for one cycle. The sign of the count sets the direction. A non-negative count moves bits toward the most significant end. A negative count moves them toward the least significant end, by the magnitude of the count.

Logical and arithmetic shifts finish in a single cycle, and so does a rotate whose count lies in -36..35. A rotate count outside that window is first brought into the window, one step of plus or minus 36 per cycle, and only then applied. While that loop runs the unit is busy and ignores `start`. An arithmetic left shift that loses significant bits sets a sticky overflow flag. The flag stays set until `ovf_clr` is raised.

Top module: `shift_rot_unit`

## Requirements
- R1: Operation code 0 selects the logical shift, 1 the rotate and 2 the arithmetic shift; code 3 behaves as code 0. Count bit 17 set means a shift toward the least significant end by the count magnitude. Bit 17 clear means a shift toward the most significant end.
- R2: A logical shift fills vacated positions with zeros. A count magnitude of 36 or more gives an all-zero result.
- R3: A rotate with a count in -36..35 moves every bit cyclically. Its result and `done` appear one cycle after the `start` cycle.
- R4: A rotate with any other count adds 36 (negative count) or subtracts 36 (positive count) once per cycle until the count lies in -36..35, and then rotates by that count. For k steps, `done` appears k+1 cycles after `start`, so a count of 36 takes 2 cycles and a count of 100 or -100 takes 3.
- R5: An arithmetic right shift fills vacated positions with copies of bit 35. A magnitude of 36 or more gives 36 copies of bit 35.
- R6: An arithmetic left shift keeps bit 35, shifts bits 34..0 left with zero fill, and sets overflow if any bit pushed out of bit 34 differs from bit 35. Counts of 35 and 36 push out all 35 of those bits.
- R7: An arithmetic left shift with a count of 37 or more sets overflow for every data word except zero. The result is bit 35 followed by 35 zeros.
- R8: `ovf` is sticky. Only `ovf_clr` clears it. If `ovf_clr` falls in the cycle where an accepted operation sets overflow, the flag ends up set.
- R9: `done` is high for exactly one cycle per operation. `result` holds its value until the next operation completes. Operations that each take one cycle may be started on consecutive cycles.
- R10: A `start` that arrives while a rotate normalization loop is running is ignored. It produces no `done` and does not change `result`.
- R11: A count of zero returns the data unchanged for all operations and never sets overflow.
- R12: After reset, `result`, `ovf` and `done` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation with the present inputs |
| op | input | 2 | 0 logical, 1 rotate, 2 arithmetic, 3 logical |
| data_in | input | 36 | Operand word |
| count | input | 18 | Two's-complement shift count |
| ovf_clr | input | 1 | Clear the sticky overflow flag |
| result | output | 36 | Last completed result |
| ovf | output | 1 | Sticky arithmetic overflow |
| done | output | 1 | One-cycle completion pulse |

## Verification
Clearing the sticky flag and setting it again can fall on the same clock edge. The bench provokes this by raising `ovf_clr` together with a `start` of an arithmetic left shift that overflows. It then expects `ovf` to read high when the completion pulse arrives. A second collision occurs when a `start` arrives while a rotate loop is running. The bench drives such starts for several cycles and judges them by the absence of any extra `done` and by a `result` that still holds the rotate value.

// File: rtl/shift_rot_unit.sv
module shift_rot_unit #(
  parameter int W  = 36,
  parameter int CW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic [W-1:0]  data_in,
  input  logic [CW-1:0] count,
  input  logic          ovf_clr,
  output logic [W-1:0]  result,
  output logic          ovf,
  output logic          done
);
  localparam int AW = $clog2(W);
  localparam logic [1:0] OP_ROT = 2'd1;
  localparam logic [1:0] OP_ARI = 2'd2;

  logic          busy;
  logic [W-1:0]  d_r;
  logic [CW-1:0] c_r;

  logic [W-1:0]  sd;
  logic [CW-1:0] sc;
  logic [1:0]    sop;
  assign sd  = busy ? d_r : data_in;
  assign sc  = busy ? c_r : count;
  assign sop = busy ? OP_ROT : op;

  logic          right;
  logic [CW:0]   mag;
  logic          big;
  logic [AW-1:0] sh;
  assign right = sc[CW-1];
  assign mag   = right ? -{sc[CW-1], sc} : {sc[CW-1], sc};
  assign big   = mag >= (CW+1)'(W);
  assign sh    = mag[AW-1:0];

  logic in_rng;
  assign in_rng = ($signed(sc) >= -$signed(CW'(W))) && ($signed(sc) <= $signed(CW'(W-1)));

  logic [AW-1:0]  amt;
  logic [2*W-1:0] dbl;
  assign amt = right ? AW'(int'($signed(sc)) + W) : AW'(sc);
  assign dbl = {sd, sd} << amt;

  logic [W-1:0] lsh_res, asr_res, asl_res, rot_res, nxt;
  assign rot_res = dbl[2*W-1:W];
  assign lsh_res = big ? '0 : (right ? sd >> sh : sd << sh);
  assign asr_res = big ? {W{sd[W-1]}} : W'($signed(sd) >>> sh);

  logic          sgn;
  logic [AW-1:0] shl;
  logic [W-2:0]  lost;
  logic          ovf_a;
  assign sgn     = sd[W-1];
  assign shl     = (mag >= (CW+1)'(W-1)) ? AW'(W-1) : sh;
  assign asl_res = {sgn, sd[W-2:0] << shl};
  assign lost    = (sd[W-2:0] ^ {(W-1){sgn}}) >> (AW'(W-1) - shl);
  assign ovf_a   = (mag > (CW+1)'(W)) ? (sd != '0) : (lost != '0);

  always_comb begin
    case (sop)
      OP_ROT:  nxt = rot_res;
      OP_ARI:  nxt = right ? asr_res : asl_res;
      default: nxt = lsh_res;
    endcase
  end

  logic accept, ovf_set;
  assign accept  = start && !busy;
  assign ovf_set = accept && (op == OP_ARI) && !right && ovf_a;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      d_r    <= '0;
      c_r    <= '0;
      result <= '0;
      ovf    <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (ovf_clr) ovf <= 1'b0;
      if (ovf_set) ovf <= 1'b1;
      if (busy) begin
        if (in_rng) begin
          result <= rot_res;
          done   <= 1'b1;
          busy   <= 1'b0;
        end else begin
          c_r <= right ? c_r + CW'(W) : c_r - CW'(W);
        end
      end else if (start) begin
        if (op == OP_ROT && !in_rng) begin
          busy <= 1'b1;
          d_r  <= data_in;
          c_r  <= right ? count + CW'(W) : count - CW'(W);
        end else begin
          result <= nxt;
          done   <= 1'b1;
        end
      end
    end
  end

  // R8
  sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !ovf_clr |=> ovf);
  // R8
  clear_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_clr && !start |=> !ovf);
  // R6
  ovf_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(start && op == OP_ARI));
  // R3
  fast_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && op == OP_ROT && $signed(count) <= 35 && $signed(count) >= -36 |=> done);
  // R4
  loop_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> busy || done);
  // R10
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !in_rng |=> !done && $stable(result));
endmodule

// File: tb/test_shift_rot_unit.sv
`timescale 1ns/1ps
module test_shift_rot_unit;
  logic        clk = 0, rst_n = 0, start = 0, ovf_clr = 0;
  logic [1:0]  op = 0;
  logic [35:0] data_in = 0;
  logic [17:0] count = 0;
  logic [35:0] result;
  logic        ovf, done;

  shift_rot_unit i_shift_rot_unit (.clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .data_in(data_in), .count(count), .ovf_clr(ovf_clr), .result(result), .ovf(ovf), .done(done));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic sticky = 0;
  logic [36:0] sb_q[$];
  string tag_q[$];

  function automatic logic [36:0] model(input logic [1:0] o, input logic [35:0] d, input int c);
    logic [35:0] r = d;
    logic v = 0;
    logic s = d[35];
    int m = c < 0 ? -c : c;
    if (o == 1) begin
      int a = ((c % 36) + 36) % 36;
      for (int i = 0; i < a; i++) r = {r[34:0], r[35]};
    end else if (o == 2) begin
      if (c < 0) for (int i = 0; i < m && i < 40; i++) r = {r[35], r[35:1]};
      else begin
        int lim = m > 35 ? 35 : m;
        for (int i = 0; i < lim; i++) begin
          if (r[34] != s) v = 1;
          r = {s, r[33:0], 1'b0};
        end
        if (m >= 37) v = (d != 0);
      end
    end else begin
      if (c < 0) for (int i = 0; i < m && i < 40; i++) r = {1'b0, r[35:1]};
      else       for (int i = 0; i < m && i < 40; i++) r = {r[34:0], 1'b0};
    end
    return {v, r};
  endfunction

  task automatic check(input bit ok, input string req, input logic [36:0] act, input logic [36:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] o, input logic [35:0] d, input int c, input bit clr, input string req);
    logic [36:0] e;
    @(negedge clk);
    e = model(o, d, c);
    sticky = clr ? e[36] : (sticky | e[36]);
    sb_q.push_back({sticky, e[35:0]});
    tag_q.push_back(req);
    op = o; data_in = d; count = 18'(c); ovf_clr = clr; start = 1;
  endtask

  task automatic release_in();
    @(negedge clk);
    start = 0; ovf_clr = 0;
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  task automatic run(input logic [1:0] o, input logic [35:0] d, input int c, input string req);
    push(o, d, c, 0, req);
    release_in();
    drain();
  endtask

  task automatic latency(input int c, input int exp, input string req);
    int n;
    push(1, 36'h8_0000_0001, c, 0, req);
    release_in();
    n = 1;
    while (!done) begin @(negedge clk); n++; end
    check(n == exp, req, 37'(n), 37'(exp));
    drain();
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb_q.size() == 0) check(0, "R9/R10 unexpected done", {ovf, result}, 37'h0);
      else begin
        logic [36:0] e;
        string t;
        e = sb_q.pop_front();
        t = tag_q.pop_front();
        check({ovf, result} === e, t, {ovf, result}, e);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(result == 0 && ovf == 0 && done == 0, "R12 reset", {ovf, result}, 37'h0);
    rst_n = 1;
    // R1 R2 logical
    run(0, 36'h8_0000_0001, 1, "R1 lsl");
    run(0, 36'hF_0000_0000, -4, "R1 lsr");
    run(3, 36'h0_0000_00F0, -4, "R1 op3 logical");
    run(0, 36'hF_FFFF_FFFF, 36, "R2 lsl 36 zero");
    run(0, 36'hF_FFFF_FFFF, -40, "R2 lsr 40 zero");
    run(0, 36'hF_FFFF_FFFF, 35, "R2 lsl 35");
    // R3 rotate fast range
    run(1, 36'h8_0000_0001, 4, "R3 rol 4");
    run(1, 36'h8_0000_0001, -1, "R3 ror 1");
    run(1, 36'h1_2345_6789, -36, "R3 ror 36");
    run(1, 36'h1_2345_6789, 35, "R3 rol 35");
    latency(5, 1, "R3 latency");
    // R4 normalization
    run(1, 36'h1_2345_6789, 100, "R4 rol 100");
    run(1, 36'h1_2345_6789, -100, "R4 ror 100");
    run(1, 36'h1_2345_6789, 131071, "R4 rol max");
    run(1, 36'h1_2345_6789, -131072, "R4 ror min");
    latency(36, 2, "R4 latency 36");
    latency(100, 3, "R4 latency 100");
    latency(-100, 3, "R4 latency -100");
    // R5 arithmetic right
    run(2, 36'h8_0000_0000, -2, "R5 asr neg");
    run(2, 36'h4_0000_0000, -3, "R5 asr pos");
    run(2, 36'h8_0000_0010, -50, "R5 asr big");
    // R6 arithmetic left
    run(2, 36'h0_0000_0005, 1, "R6 asl clean");
    run(2, 36'hF_FFFF_FFF0, 4, "R6 asl neg clean");
    run(2, 36'h0_0000_0001, 3, "R6 asl ok");
    // R11 zero count
    run(0, 36'hA_5A5A_5A5A, 0, "R11 lsh 0");
    run(1, 36'hA_5A5A_5A5A, 0, "R11 rot 0");
    run(2, 36'hA_5A5A_5A5A, 0, "R11 ash 0");
    run(2, 36'h4_0000_0000, 1, "R6 asl overflow");
    run(0, 36'h0_0000_0003, 2, "R8 sticky after clean op");
    @(negedge clk); ovf_clr = 1; sticky = 0;
    @(negedge clk); ovf_clr = 0;
    check(ovf == 0, "R8 clear", {36'h0, ovf}, 37'h0);
    // R7
    run(2, 36'h0, 37, "R7 zero no ovf");
    run(2, 36'hF_FFFF_FFFF, 37, "R7 ones ovf");
    @(negedge clk); ovf_clr = 1; sticky = 0;
    @(negedge clk); ovf_clr = 0;
    run(2, 36'hF_FFFF_FFFF, 36, "R6 ones count 36 no ovf");
    run(2, 36'h0_0000_0001, 36, "R6 count 36 ovf");
    // R8 clear and set on the same edge
    @(negedge clk); ovf_clr = 1; sticky = 0;
    @(negedge clk); ovf_clr = 0;
    push(2, 36'h2_0000_0000, 2, 1, "R8 clear with set");
    release_in();
    drain();
    // R9 back-to-back single-cycle ops
    push(0, 36'h0_0000_0001, 1, 0, "R9 b2b a");
    push(1, 36'h0_0000_0001, -1, 0, "R9 b2b b");
    push(2, 36'h8_0000_0000, -1, 0, "R9 b2b c");
    release_in();
    drain();
    // R10 start ignored while busy
    push(1, 36'h1_2345_6789, 1000, 0, "R10 long rotate");
    @(negedge clk); op = 0; data_in = 36'hF_FFFF_FFFF; count = 1;
    repeat (3) @(negedge clk);
    start = 0;
    drain();
    repeat (4) @(negedge clk);
    check(result == model(1, 36'h1_2345_6789, 1000) >> 0 & 37'h0F_FFFF_FFFF, "R10 result held",
          {1'b0, result}, model(1, 36'h1_2345_6789, 1000) & 37'h0F_FFFF_FFFF);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule